// File: doc/BRIEF.md
# XOR Outer-Product Scan Data Decompressor

The block rebuilds scan test vectors from a serial compressed stream. The stream is a run of records. A two-bit record code picks one of three square block sizes or a raw literal. A square record of size n carries two n-bit vectors, A and B. The block expands them into n rows, where element j of row i is A[i] XOR B[j]. So 2n stream bits rebuild n*n scan bits. A literal record carries M bits, which go out unchanged as a single row.

Rows leave on a word-wide valid/ready interface. A width field gives the number of meaningful bits in each row, and bit 0 is the first bit to shift. The block counts delivered bits against a configured scan length. When a vector is complete it pulses a capture request and advances a vector count. It stops after a configured number of vectors. A stream that ends inside a record sets a sticky error flag.

Top module: `xdd_decomp`

## Requirements
- R1: A record code is two stream bits, the first received being the MSB; code 0 selects size N1, code 1 size N2, code 2 size N3, code 3 a literal of M bits.
- R2: After a square-record code, the stream carries A[0..n-1] and then B[0..n-1], lowest index first.
- R3: A square record of size n yields rows 0..n-1 in order; bit j of row i equals A[i] XOR B[j].
- R4: A literal record yields a single row whose bit k is the k-th literal bit received.
- R5: out_width equals the number of valid bits in the row (n, or M for a literal, unless shortened by R7), and every out_row bit at or above out_width is 0.
- R6: While out_valid is high and out_ready is low, out_row and out_width hold their values; in_ready is low whenever out_valid is high.
- R7: Each vector holds SCAN_LEN bits. A row that reaches the vector end is cut to the remaining bit count, and the rows of that record that are left over are dropped.
- R8: capture is high for exactly one cycle, the cycle after the handshake of a vector's final row, and vec_count is incremented in that same cycle.
- R9: Once NUM_VEC vectors are complete, done stays high, in_ready stays low and no further rows appear.
- R10: err is set, and stays set until reset, when in_last accompanies an accepted bit that is not the final bit of its record; in_last on a record's final bit leaves err low.
- R11: After reset, out_valid, capture, done and err are low, vec_count is 0, and the block expects a record code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Stream bit valid |
| in_bit | input | 1 | Stream bit |
| in_last | input | 1 | Marks the final bit of the stream |
| in_ready | output | 1 | Block accepts a stream bit |
| out_valid | output | 1 | Row valid |
| out_ready | input | 1 | Downstream accepts the row |
| out_row | output | DW | Row bits, bit 0 first in scan order |
| out_width | output | WW | Number of valid bits in out_row |
| capture | output | 1 | One-cycle capture request at vector end |
| vec_count | output | VW | Vectors completed |
| done | output | 1 | All vectors produced |
| err | output | 1 | Stream ended inside a record (sticky) |

## Verification
The hardest case to reach from the ports is a vector boundary that falls at every possible row position inside a record, for both square and literal records. Only then are the truncation and the dropping of leftover rows exercised. The bench picks a scan length that is not a multiple of any block size. It then feeds a long chain of records with a cycling mix of codes, so the boundary drifts through many different row offsets and row widths. Output back-pressure is applied at random to cover the hold behaviour. A separate phase after a second reset cuts the stream off inside the A vector to reach the error path.

// File: rtl/xdd_pkg.sv
package xdd_pkg;

  typedef enum logic [2:0] {
    ST_CODE_HI = 3'd0,
    ST_CODE_LO = 3'd1,
    ST_LOAD_A  = 3'd2,
    ST_LOAD_B  = 3'd3,
    ST_LOAD_L  = 3'd4,
    ST_EMIT    = 3'd5,
    ST_FIN     = 3'd6
  } xdd_state_e;

  typedef enum logic [1:0] {
    CODE_SZ1 = 2'd0,
    CODE_SZ2 = 2'd1,
    CODE_SZ3 = 2'd2,
    CODE_LIT = 2'd3
  } xdd_code_e;

endpackage

// File: rtl/xdd_rstsync.sv
module xdd_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/xdd_parser.sv
module xdd_parser
  import xdd_pkg::*;
#(
  parameter int N1 = 16,
  parameter int N2 = 8,
  parameter int N3 = 4,
  parameter int M  = 10,
  parameter int DW = 16,
  parameter int WW = 5,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          row_fire,
  input  logic          vec_end,
  input  logic          last_vec,
  output logic          emit,
  output logic          is_lit,
  output logic [WW-1:0] size,
  output logic [IW-1:0] row_idx,
  output logic [DW-1:0] a_vec,
  output logic [DW-1:0] b_vec,
  output logic          err
);

  function automatic logic [WW-1:0] size_of(input logic [1:0] code);
    case (code)
      CODE_SZ1: size_of = WW'(N1);
      CODE_SZ2: size_of = WW'(N2);
      CODE_SZ3: size_of = WW'(N3);
      default:  size_of = WW'(M);
    endcase
  endfunction

  xdd_state_e    st_q, st_d;
  logic          hi_q, hi_d;
  logic          lit_q, lit_d;
  logic [WW-1:0] n_q, n_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] a_q, a_d;
  logic [DW-1:0] b_q, b_d;
  logic          err_q, err_d;
  logic          acc;
  logic          at_end;
  logic [1:0]    code_w;

  assign in_ready = (st_q == ST_CODE_HI) || (st_q == ST_CODE_LO) ||
                    (st_q == ST_LOAD_A)  || (st_q == ST_LOAD_B)  ||
                    (st_q == ST_LOAD_L);
  assign acc    = in_valid && in_ready;
  assign at_end = (cnt_q == IW'(n_q - WW'(1)));
  assign code_w = {hi_q, in_bit};

  always_comb begin
    st_d  = st_q;
    hi_d  = hi_q;
    lit_d = lit_q;
    n_d   = n_q;
    cnt_d = cnt_q;
    a_d   = a_q;
    b_d   = b_q;
    err_d = err_q;
    case (st_q)
      ST_CODE_HI: begin
        if (acc) begin
          hi_d = in_bit;
          st_d = ST_CODE_LO;
          if (in_last) err_d = 1'b1;
        end
      end
      ST_CODE_LO: begin
        if (acc) begin
          n_d   = size_of(code_w);
          lit_d = (code_w == CODE_LIT);
          cnt_d = '0;
          st_d  = (code_w == CODE_LIT) ? ST_LOAD_L : ST_LOAD_A;
          if (in_last) err_d = 1'b1;
        end
      end
      ST_LOAD_A: begin
        if (acc) begin
          a_d[cnt_q] = in_bit;
          if (in_last) err_d = 1'b1;
          if (at_end) begin
            cnt_d = '0;
            st_d  = ST_LOAD_B;
          end else begin
            cnt_d = cnt_q + IW'(1);
          end
        end
      end
      ST_LOAD_B, ST_LOAD_L: begin
        if (acc) begin
          if (st_q == ST_LOAD_B) b_d[cnt_q] = in_bit;
          else                   a_d[cnt_q] = in_bit;
          if (at_end) begin
            cnt_d = '0;
            st_d  = ST_EMIT;
          end else begin
            cnt_d = cnt_q + IW'(1);
            if (in_last) err_d = 1'b1;
          end
        end
      end
      ST_EMIT: begin
        if (row_fire) begin
          if (vec_end) begin
            cnt_d = '0;
            st_d  = last_vec ? ST_FIN : ST_CODE_HI;
          end else if (lit_q || at_end) begin
            cnt_d = '0;
            st_d  = ST_CODE_HI;
          end else begin
            cnt_d = cnt_q + IW'(1);
          end
        end
      end
      default: st_d = ST_FIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_CODE_HI;
      hi_q  <= 1'b0;
      lit_q <= 1'b0;
      n_q   <= '0;
      cnt_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (acc || row_fire) begin
        hi_q  <= hi_d;
        lit_q <= lit_d;
        n_q   <= n_d;
        cnt_q <= cnt_d;
        a_q   <= a_d;
        b_q   <= b_d;
      end
    end
  end

  assign emit    = (st_q == ST_EMIT);
  assign is_lit  = lit_q;
  assign size    = n_q;
  assign row_idx = cnt_q;
  assign a_vec   = a_q;
  assign b_vec   = b_q;
  assign err     = err_q;
endmodule

// File: rtl/xdd_rowgen.sv
module xdd_rowgen #(
  parameter int DW = 16,
  parameter int WW = 5,
  parameter int IW = 4,
  parameter int RW = 7
) (
  input  logic          is_lit,
  input  logic [WW-1:0] size,
  input  logic [IW-1:0] row_idx,
  input  logic [DW-1:0] a_vec,
  input  logic [DW-1:0] b_vec,
  input  logic [RW-1:0] remain,
  output logic [DW-1:0] row,
  output logic [WW-1:0] width,
  output logic          vec_end
);
  logic a_sel;

  always_comb begin
    a_sel   = a_vec[row_idx];
    vec_end = (int'(size) >= int'(remain));
    width   = vec_end ? WW'(remain) : size;
  end

  for (genvar j = 0; j < DW; j++) begin : g_col
    logic raw;
    assign raw    = is_lit ? a_vec[j] : (a_sel ^ b_vec[j]);
    assign row[j] = (WW'(j) < width) ? raw : 1'b0;
  end
endmodule

// File: rtl/xdd_vtrack.sv
module xdd_vtrack #(
  parameter int SCAN_LEN = 64,
  parameter int NUM_VEC  = 4,
  parameter int WW       = 5,
  parameter int RW       = 7,
  parameter int VW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_fire,
  input  logic          vec_end,
  input  logic [WW-1:0] width,
  output logic [RW-1:0] remain,
  output logic          last_vec,
  output logic          capture,
  output logic [VW-1:0] vec_count,
  output logic          done
);
  logic [RW-1:0] rem_q, rem_d;
  logic [VW-1:0] vc_q, vc_d;
  logic          cap_d, cap_q;

  always_comb begin
    rem_d = rem_q;
    vc_d  = vc_q;
    cap_d = 1'b0;
    if (row_fire) begin
      if (vec_end) begin
        rem_d = RW'(SCAN_LEN);
        vc_d  = vc_q + VW'(1);
        cap_d = 1'b1;
      end else begin
        rem_d = rem_q - RW'(width);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= RW'(SCAN_LEN);
      vc_q  <= '0;
      cap_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      if (row_fire) begin
        rem_q <= rem_d;
        vc_q  <= vc_d;
      end
    end
  end

  assign remain    = rem_q;
  assign last_vec  = (vc_q == VW'(NUM_VEC - 1));
  assign capture   = cap_q;
  assign vec_count = vc_q;
  assign done      = (vc_q == VW'(NUM_VEC));
endmodule

// File: rtl/xdd_decomp.sv
module xdd_decomp #(
  parameter int N1       = 16,
  parameter int N2       = 8,
  parameter int N3       = 4,
  parameter int M        = 10,
  parameter int SCAN_LEN = 64,
  parameter int NUM_VEC  = 4,
  localparam int DW = (N1 > M) ? N1 : M,
  localparam int WW = $clog2(DW + 1),
  localparam int IW = (DW > 1) ? $clog2(DW) : 1,
  localparam int RW = $clog2(SCAN_LEN + 1),
  localparam int VW = $clog2(NUM_VEC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic          in_last,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_row,
  output logic [WW-1:0] out_width,
  output logic          capture,
  output logic [VW-1:0] vec_count,
  output logic          done,
  output logic          err
);
  logic          rst_i_n;
  logic          emit, is_lit, vec_end, last_vec, row_fire;
  logic [WW-1:0] size;
  logic [IW-1:0] row_idx;
  logic [DW-1:0] a_vec, b_vec;
  logic [RW-1:0] remain;

  assign out_valid = emit;
  assign row_fire  = emit && out_ready;

  xdd_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  xdd_parser #(
    .N1(N1), .N2(N2), .N3(N3), .M(M), .DW(DW), .WW(WW), .IW(IW)
  ) u_parse (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_last  (in_last),
    .in_ready (in_ready),
    .row_fire (row_fire),
    .vec_end  (vec_end),
    .last_vec (last_vec),
    .emit     (emit),
    .is_lit   (is_lit),
    .size     (size),
    .row_idx  (row_idx),
    .a_vec    (a_vec),
    .b_vec    (b_vec),
    .err      (err)
  );

  xdd_rowgen #(
    .DW(DW), .WW(WW), .IW(IW), .RW(RW)
  ) u_row (
    .is_lit  (is_lit),
    .size    (size),
    .row_idx (row_idx),
    .a_vec   (a_vec),
    .b_vec   (b_vec),
    .remain  (remain),
    .row     (out_row),
    .width   (out_width),
    .vec_end (vec_end)
  );

  xdd_vtrack #(
    .SCAN_LEN(SCAN_LEN), .NUM_VEC(NUM_VEC), .WW(WW), .RW(RW), .VW(VW)
  ) u_vec (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .row_fire  (row_fire),
    .vec_end   (vec_end),
    .width     (out_width),
    .remain    (remain),
    .last_vec  (last_vec),
    .capture   (capture),
    .vec_count (vec_count),
    .done      (done)
  );
endmodule

// File: rtl/xdd_decomp_chk.sv
module xdd_decomp_chk #(
  parameter int DW = 16,
  parameter int WW = 5,
  parameter int VW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_row,
  input logic [WW-1:0] out_width,
  input logic          capture,
  input logic [VW-1:0] vec_count,
  input logic          done,
  input logic          err
);
  // R6: a stalled row is held unchanged
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_width));

  // R6: no stream intake while a row is offered
  p_no_intake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R5: width in range and bits above it cleared
  p_width_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_width != '0) && (int'(out_width) <= DW));

  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_row >> out_width) == '0));

  // R8: capture is a single-cycle pulse following a row handshake
  p_cap_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

  p_cap_after_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> $past(out_valid && out_ready));

  p_cap_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (vec_count == $past(vec_count) + VW'(1)));

  // R9: finished state is permanent and quiet
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !in_ready && !out_valid);

  // R10: error is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind xdd_decomp xdd_decomp_chk #(.DW(DW), .WW(WW), .VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_row   (out_row),
  .out_width (out_width),
  .capture   (capture),
  .vec_count (vec_count),
  .done      (done),
  .err       (err)
);

// File: tb/xdd_decomp_tb.sv
module xdd_decomp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N1 = 16, N2 = 8, N3 = 4, M = 10;
  localparam int SCAN_LEN = 37;
  localparam int NUM_VEC  = 12;
  localparam int DW = 16;
  localparam int WW = 5;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_bit, in_last, in_ready;
  logic          out_valid, out_ready;
  logic [DW-1:0] out_row;
  logic [WW-1:0] out_width;
  logic          capture;
  logic [VW-1:0] vec_count;
  logic          done, err;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xdd_decomp #(
    .N1(N1), .N2(N2), .N3(N3), .M(M), .SCAN_LEN(SCAN_LEN), .NUM_VEC(NUM_VEC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_row(out_row), .out_width(out_width),
    .capture(capture), .vec_count(vec_count), .done(done), .err(err)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic l);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    in_last  = l;
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  int rem_exp;
  int vec_exp;

  task automatic recv_row(input logic [DW-1:0] erow, input int ew, input logic eend);
    logic [DW-1:0] prow;
    logic [WW-1:0] pw;
    logic          stalled;
    stalled = 1'b0;
    prow = '0;
    pw = '0;
    forever begin
      @(negedge clk);
      if (out_valid) check("R6 in_ready low during row", in_ready, 0);
      if (stalled) begin
        check("R6 row held", out_row, prow);
        check("R6 width held", out_width, pw);
      end
      out_ready = ($urandom_range(0, 3) != 0);
      if (out_valid && out_ready) break;
      stalled = out_valid;
      prow = out_row;
      pw = out_width;
    end
    check("R1 R2 R3 R4 row data", out_row, erow);
    check("R5 R7 row width", out_width, ew);
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 capture pulse", capture, eend);
    if (eend) check("R8 vector count", vec_count, vec_exp);
  endtask

  task automatic run_record(input logic [1:0] code, input logic [DW-1:0] av,
                            input logic [DW-1:0] bv);
    int n;
    int rows;
    n = (code == 2'd0) ? N1 : (code == 2'd1) ? N2 : (code == 2'd2) ? N3 : M;
    send_bit(code[1], 1'b0);
    send_bit(code[0], 1'b0);
    if (code == 2'd3) begin
      for (int k = 0; k < M; k++) send_bit(av[k], k == M - 1);
      rows = 1;
    end else begin
      for (int k = 0; k < n; k++) send_bit(av[k], 1'b0);
      for (int k = 0; k < n; k++) send_bit(bv[k], k == n - 1);
      rows = n;
    end
    for (int i = 0; i < rows; i++) begin
      logic [DW-1:0] er;
      int w;
      logic vend;
      vend = (n >= rem_exp);
      w = vend ? rem_exp : n;
      er = '0;
      for (int j = 0; j < w; j++)
        er[j] = (code == 2'd3) ? av[j] : (av[i] ^ bv[j]);
      if (vend) begin
        vec_exp++;
        rem_exp = SCAN_LEN;
      end else begin
        rem_exp -= w;
      end
      recv_row(er, w, vend);
      if (vend) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0; in_bit = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rem_exp = SCAN_LEN;
    vec_exp = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int rec;
    do_reset();
    // R11 reset state
    check("R11 out_valid", out_valid, 0);
    check("R11 capture", capture, 0);
    check("R11 done", done, 0);
    check("R11 err", err, 0);
    check("R11 vec_count", vec_count, 0);
    check("R11 in_ready", in_ready, 1);

    rec = 0;
    while (vec_exp < NUM_VEC) begin
      logic [1:0] code;
      code = (rec < 16) ? 2'(rec % 4) : 2'($urandom_range(0, 3));
      run_record(code, DW'($urandom), DW'($urandom));
      rec++;
    end
    check("R10 legal ends leave err low", err, 0);
    check("R9 done", done, 1);
    check("R9 count", vec_count, NUM_VEC);
    in_valid = 1'b1;
    out_ready = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 in_ready stays low", in_ready, 0);
    check("R9 no more rows", out_valid, 0);
    check("R9 count unchanged", vec_count, NUM_VEC);
    in_valid = 1'b0;
    out_ready = 1'b0;

    do_reset();
    check("R11 err after reset", err, 0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    check("R10 no err before last", err, 0);
    send_bit(1'b0, 1'b1);
    check("R10 err on early end", err, 1);
    repeat (3) @(negedge clk);
    check("R10 err sticky", err, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule